// File: doc/BRIEF.md
# Four-Tap Distributed-Arithmetic Dot Product

This block forms the dot product of four signed weights with the four most recent signed input samples, and uses no multiplier to do it. A bank of fifteen registers holds every non-empty subset sum of the four stored samples. Each time a new sample is accepted, the bank is rebuilt in a single cycle. Entries whose subset leaves out the newest tap take over shifted values from the previous bank. The lone newest sample is written straight in, and seven adders form the sums that contain it.

The weights are consumed one bit position per clock, least significant first. The four bits of a position form a 4-bit address into the bank. A 16-way selector returns the addressed subset sum, with address zero returning zero. A carry-save accumulator adds each selected sum, shifted to its bit weight, without resolving carries. On the sign position the shifted sum is bitwise inverted. One closing addition with a carry-in of 1 merges the two words and completes the two's-complement subtraction. The block then subtracts the result from a desired sample to give an error term, and raises a one-cycle completion strobe.

Top module: `da_inner4`

## Requirements
- R1: `result` equals the sum over k of w_k * x_k. Weight lane k occupies `weights_in[k*WL +: WL]`. x_0 is the newest accepted sample and x_3 is the oldest. All values are two's complement.
- R2: A bit position in which all four weights hold 0 adds nothing. All-zero weights give a result of 0 whatever the sample history holds.
- R3: Each accepted start shifts `sample_in` into the history as x_0 and discards the oldest sample. After reset the history holds four zeros.
- R4: `start` is accepted at a rising edge when the block is idle. `done` is then high for exactly one cycle, which follows the (WL+1)-th rising edge after the accepting edge.
- R5: When `done` is high, `err` equals `desired_in`, as captured at the accepting edge, minus `result`, wrapped to the output width.
- R6: A `start` that arrives before `done` has been raised for the current operation is ignored. It leaves the sample history, the result and the error unchanged.
- R7: The weights and the desired value are captured at the accepting edge. Changes to them during the computation do not affect the result.
- R8: While reset is asserted and after it is released, `result`, `err` and `done` are 0.
- R9: The most significant weight bit carries negative weight. A weight of -2^(WL-1) times a sample of -2^(XW-1) on every tap gives +4*2^(WL+XW-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept a new sample and begin a computation |
| sample_in | input | XW | New signed input sample |
| weights_in | input | 4*WL | Four signed weights; lane k at [k*WL +: WL] |
| desired_in | input | XW+2+WL | Signed desired value |
| result | output | XW+2+WL | Signed dot product |
| err | output | XW+2+WL | Desired value minus result |
| done | output | 1 | One-cycle strobe: result and err are valid |

## Verification
The hardest case to reach from the ports is a start request that arrives mid-computation, together with new weights and a new desired value. This exercises both the busy guard and the weight capture. The stimulus raises `start` a few cycles into a run with inverted data on every input. It then checks that the current result is unaffected, and that the next operation's expected value assumes the intruding sample was never stored. The sign position is reached with weights of -128 on every tap and extreme negative samples. A pseudo-random sequence then compares every result against a direct multiply-accumulate over the bench's own sample history.

// File: rtl/da_inner_pkg.sv
package da_inner_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_MERGE = 2'd2
  } phase_e;
endpackage

// File: rtl/da_subset_table.sv
// Bank of the fifteen non-empty subset sums of the four most recent samples.
// Bit k of the address selects tap k (tap 0 is the newest).
module da_subset_table #(
  parameter int XW = 8,
  parameter int TW = XW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [XW-1:0]        x_new,
  input  logic [3:0]           sel,
  output logic signed [TW-1:0] entry
);
  localparam int NE   = 16;
  localparam int HALF = NE / 2;

  logic signed [TW-1:0] x_ext;
  logic signed [TW-1:0] tab_q [1:NE-1];
  logic signed [TW-1:0] tab_d [1:NE-1];
  logic signed [TW-1:0] with_new [1:HALF-1];

  assign x_ext = {{(TW-XW){x_new[XW-1]}}, x_new};

  // Seven parallel adders: old subset j plus the incoming sample.
  for (genvar j = 1; j < HALF; j++) begin : g_add
    assign with_new[j] = tab_q[j] + x_ext;
  end

  always_comb begin
    for (int i = 1; i < NE; i++) tab_d[i] = tab_q[i];
    if (load) begin
      tab_d[1] = x_ext;
      for (int j = 1; j < HALF; j++) begin
        tab_d[2*j]   = tab_q[j];
        tab_d[2*j+1] = with_new[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NE; i++) tab_q[i] <= '0;
    end else if (load) begin
      for (int i = 1; i < NE; i++) tab_q[i] <= tab_d[i];
    end
  end

  always_comb begin
    if (sel == 4'd0) entry = '0;
    else             entry = tab_q[sel];
  end

  a_r3_newest_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tab_q[1] == $past(x_ext));
  a_r3_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> tab_q[8] == $past(tab_q[4]));
  a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(tab_q[15]));
endmodule

// File: rtl/da_csa_accum.sv
// Carry-save accumulation of shifted subset sums; sign position inverted.
module da_csa_accum #(
  parameter int TW = 10,
  parameter int WL = 8,
  parameter int OW = TW + WL,
  parameter int SW = $clog2(WL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 negate,
  input  logic [SW-1:0]        shamt,
  input  logic signed [TW-1:0] entry,
  output logic [OW-1:0]        sum_q,
  output logic [OW-1:0]        car_q
);
  logic [OW-1:0] widened;
  logic [OW-1:0] addend;
  logic [OW-1:0] sum_d;
  logic [OW-1:0] car_d;

  always_comb begin
    widened = {{(OW-TW){entry[TW-1]}}, entry} << shamt;
    addend  = negate ? ~widened : widened;
    sum_d   = sum_q;
    car_d   = car_q;
    if (clr) begin
      sum_d = '0;
      car_d = '0;
    end else if (en) begin
      sum_d = sum_q ^ car_q ^ addend;
      car_d = ((sum_q & car_q) | (sum_q & addend) | (car_q & addend)) << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      car_q <= '0;
    end else if (clr || en) begin
      sum_q <= sum_d;
      car_q <= car_d;
    end
  end

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0) && (car_q == '0));
  a_r2_zero_adds_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !negate && entry == '0) |=> (sum_q + car_q) == $past(sum_q + car_q));
endmodule

// File: rtl/da_inner4.sv
module da_inner4 #(
  parameter int XW = 8,
  parameter int WL = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [XW-1:0]        sample_in,
  input  logic [4*WL-1:0]      weights_in,
  input  logic [XW+2+WL-1:0]   desired_in,
  output logic [XW+2+WL-1:0]   result,
  output logic [XW+2+WL-1:0]   err,
  output logic                 done
);
  import da_inner_pkg::*;

  localparam int TW = XW + 2;
  localparam int OW = TW + WL;
  localparam int CW = $clog2(WL);
  localparam int TAPS = 4;
  localparam logic [CW-1:0] LAST = CW'(WL - 1);

  phase_e              phase_q, phase_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [TAPS*WL-1:0]  w_q;
  logic [OW-1:0]       d_q;
  logic [OW-1:0]       res_q, res_d;
  logic [OW-1:0]       err_q, err_d;
  logic                done_q, done_d;
  logic                accept;
  logic [TAPS-1:0]     slice;
  logic signed [TW-1:0] entry;
  logic [OW-1:0]       sum_w, car_w, merged;

  assign accept = start && (phase_q == PH_IDLE);

  for (genvar k = 0; k < TAPS; k++) begin : g_slice
    assign slice[k] = w_q[k*WL + int'(cnt_q)];
  end

  da_subset_table #(.XW(XW), .TW(TW)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .x_new (sample_in),
    .sel   (slice),
    .entry (entry)
  );

  da_csa_accum #(.TW(TW), .WL(WL), .OW(OW), .SW(CW)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .en     (phase_q == PH_RUN),
    .negate (cnt_q == LAST),
    .shamt  (cnt_q),
    .entry  (entry),
    .sum_q  (sum_w),
    .car_q  (car_w)
  );

  assign merged = sum_w + car_w + OW'(1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    res_d   = res_q;
    err_d   = err_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_RUN;
        cnt_d   = '0;
      end
      PH_RUN: begin
        if (cnt_q == LAST) phase_d = PH_MERGE;
        else               cnt_d   = cnt_q + CW'(1);
      end
      PH_MERGE: begin
        res_d   = merged;
        err_d   = d_q - merged;
        done_d  = 1'b1;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      res_q   <= '0;
      err_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      d_q <= '0;
    end else if (accept) begin
      w_q <= weights_in;
      d_q <= desired_in;
    end
  end

  assign result = res_q;
  assign err    = err_q;
  assign done   = done_q;

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r4_done_from_merge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(phase_q) == PH_MERGE);
  a_r5_err_balance: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (res_q + err_q) == d_q);
  a_r7_weights_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> $stable(w_q) && $stable(d_q));
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && !done_q) |=> !done_q);
endmodule

// File: tb/da_inner4_test.sv
`timescale 1ns/1ps
module da_inner4_test;
  localparam int XW = 8;
  localparam int WL = 8;
  localparam int OW = XW + 2 + WL;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [XW-1:0]     sample_in;
  logic [4*WL-1:0]   weights_in;
  logic [OW-1:0]     desired_in;
  logic [OW-1:0]     result;
  logic [OW-1:0]     err;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;
  int hist [4];
  int wv [4];
  int seed = 12345;

  always #2 clk = ~clk;

  da_inner4 #(.XW(XW), .WL(WL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_in(sample_in),
    .weights_in(weights_in), .desired_in(desired_in),
    .result(result), .err(err), .done(done)
  );

  function automatic int wrap_ow(input int v);
    logic [OW-1:0] t;
    t = OW'(v);
    return int'($signed(t));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One operation; disturb injects a start with fresh data mid-run (R6, R7).
  task automatic do_op(input int x, input int d, input string tag, input bit disturb);
    int y;
    int k;
    @(negedge clk);
    sample_in  = XW'(x);
    for (int i = 0; i < 4; i++) weights_in[i*WL +: WL] = WL'(wv[i]);
    desired_in = OW'(d);
    start = 1'b1;
    for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    y = 0;
    for (int i = 0; i < 4; i++) y += wv[i] * hist[i];
    @(negedge clk);
    start = 1'b0;
    k = 1;
    while (!done && k < 40) begin
      if (disturb && k == 3) begin
        start = 1'b1;
        sample_in = ~sample_in;
        weights_in = ~weights_in;
        desired_in = desired_in + OW'(77);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check({tag, " R4 latency"}, k, WL + 2);
    check({tag, " R1 result"}, int'($signed(result)), wrap_ow(y));
    check({tag, " R5 err"}, int'($signed(err)), wrap_ow(d - y));
    @(negedge clk);
    check({tag, " R4 strobe width"}, int'(done), 0);
  endtask

  task automatic t_reset;
    check("R8 reset result", int'(result), 0);
    check("R8 reset err", int'(err), 0);
    check("R8 reset done", int'(done), 0);
  endtask

  task automatic t_fill;
    wv = '{3, -5, 7, 2};
    do_op(10, 0, "fill1 R3", 1'b0);
    do_op(-20, 100, "fill2 R3", 1'b0);
    do_op(30, -7, "fill3 R3", 1'b0);
    do_op(-40, 5, "fill4 R3", 1'b0);
    do_op(55, 1000, "fill5 R3 oldest dropped", 1'b0);
  endtask

  task automatic t_zero_weights;
    wv = '{0, 0, 0, 0};
    do_op(99, 321, "R2 zero weights", 1'b0);
  endtask

  task automatic t_sign_corner;
    wv = '{-128, -128, -128, -128};
    for (int i = 0; i < 4; i++) do_op(-128, 0, "R9 neg x neg", 1'b0);
    check("R9 full magnitude", int'($signed(result)), 65536);
    wv = '{-128, 127, -1, 1};
    do_op(127, -131072, "R9 mixed R5 wrap", 1'b0);
  endtask

  task automatic t_busy;
    wv = '{17, -33, 64, -2};
    do_op(44, 9, "R6 R7 busy start", 1'b1);
    do_op(-3, 0, "R6 history after ignore", 1'b0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 24; n++) begin
      for (int i = 0; i < 4; i++) begin
        seed = seed * 1103515245 + 12345;
        wv[i] = int'($signed(8'(seed >>> 16)));
      end
      seed = seed * 1103515245 + 12345;
      do_op(int'($signed(8'(seed >>> 16))), (seed >>> 8) % 5000, "R1 random", 1'b0);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    sample_in = '0;
    weights_in = '0;
    desired_in = '0;
    for (int i = 0; i < 4; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_zero_weights;
    t_sign_corner;
    t_busy;
    t_random;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule